// File: doc/BRIEF.md
# Video Memory Address Mirroring Decoder

This block sits on the video side of a tile-based picture generator and turns a 14-bit video address into a location in one of two internal stores: a 4 KB nametable RAM built as four physical 1 KB banks, and a 32-byte palette RAM. The nametable window is cut into four logical 1 KB tables. A 3-bit mirroring mode, supplied by the cartridge, chooses which physical bank each logical table lands on. The window just above the nametables repeats the nametable window. The palette window repeats its 32 entries, and the four sprite backdrop slots share storage with their background counterparts.

Access is a plain synchronous bus. Each cycle the caller presents an address, a write enable and write data. A write lands on the rising edge where the enable is high. Read data appears one cycle after the address and is registered.

A small three-state machine records which store the current cycle's access targets, so that the next cycle's output mux picks the right source. The states are SRC_NONE (no store, the reset state), SRC_NAME (nametable RAM) and SRC_PAL (palette RAM). There is one transition rule: from any state, the next state is the region decoded from the address presented this cycle. An address below 0x2000 moves the machine to SRC_NONE. An address in 0x2000..0x3EFF moves it to SRC_NAME. An address in 0x3F00..0x3FFF moves it to SRC_PAL.

Top module: `vram_mirror_decoder`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `rd_data` is 0.
- R2: A write to an address stores `wr_data` on the clock edge where `wr_en` is high. The value at the address presented in cycle N appears on `rd_data` in cycle N+1.
- R3: Nametable addresses use bits [11:10] as the logical table and bits [9:0] as the offset. The physical location is bank*0x400 + offset. With `mirror_mode` 0 (horizontal), tables 0,1,2,3 map to banks 0,0,1,1.
- R4: With `mirror_mode` 1 (vertical), tables 0,1,2,3 map to banks 0,1,0,1.
- R5: With `mirror_mode` 2 (four separate screens), tables 0,1,2,3 map to banks 0,1,2,3.
- R6: With `mirror_mode` 3, every table maps to bank 0. With `mirror_mode` 4, every table maps to bank 1.
- R7: The unused `mirror_mode` values 5, 6 and 7 behave exactly as mode 0.
- R8: An address in 0x3000..0x3EFF reaches the same storage as that address minus 0x1000, for both reads and writes.
- R9: An address in 0x3F00..0x3FFF selects palette entry addr[4:0], so the 32 entries repeat every 0x20 across the window.
- R10: Palette entries 0x10, 0x14, 0x18 and 0x1C are folded to 0x00, 0x04, 0x08 and 0x0C for both reads and writes. No other entry is folded.
- R11: An access below 0x2000 returns 0 on `rd_data`, and a write there changes no storage.
- R12: When a read and a write hit the same location in the same cycle, `rd_data` in the next cycle shows the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the read-source state |
| mirror_mode | input | 3 | Table-to-bank mirroring selection (0 horiz, 1 vert, 2 four-screen, 3 bank 0, 4 bank 1) |
| addr | input | 14 | Video-side address |
| wr_en | input | 1 | Write enable for this cycle's address |
| wr_data | input | 8 | Data written when `wr_en` is high |
| rd_data | output | 8 | Registered read data for the previous cycle's address |

## Verification
The assertions assume that `mirror_mode`, `addr` and `wr_en` are known and settled before every rising edge while reset is released. They also assume that mode changes take effect on the very next access, with no settling window. The bench drives every input on the falling edge, so the values are stable at each rising edge. It changes the mode only between accesses. It writes every location before it reads it, because the RAM contents are not reset. Reads that check a folded or mirrored location always follow a write made through a different alias.

// File: rtl/vmd_pkg.sv
package vmd_pkg;

    localparam int VADDR_W = 14;

    typedef enum logic [2:0] {
        MODE_HORIZ  = 3'd0,
        MODE_VERT   = 3'd1,
        MODE_FOUR   = 3'd2,
        MODE_ONE_LO = 3'd3,
        MODE_ONE_HI = 3'd4
    } mirror_mode_e;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_NAME = 2'd1,
        SRC_PAL  = 2'd2
    } src_e;

    function automatic logic [1:0] bank_of(input logic [2:0] mode, input logic [1:0] tbl);
        logic [1:0] b;
        case (mode)
            MODE_VERT:   b = {1'b0, tbl[0]};
            MODE_FOUR:   b = tbl;
            MODE_ONE_LO: b = 2'd0;
            MODE_ONE_HI: b = 2'd1;
            default:     b = {1'b0, tbl[1]};
        endcase
        return b;
    endfunction

endpackage

// File: rtl/vmd_addr_map.sv
module vmd_addr_map
    import vmd_pkg::*;
#(
    parameter int OFS_W = 10,
    parameter int PAL_W = 5,
    localparam int NT_AW = OFS_W + 2
) (
    input  logic [2:0]         mode,
    input  logic [VADDR_W-1:0] addr,
    output src_e               region,
    output logic [NT_AW-1:0]   nt_index,
    output logic [PAL_W-1:0]   pal_index
);

    logic [1:0] tbl;
    logic [1:0] bank;

    always_comb begin
        if (!addr[13])
            region = SRC_NONE;
        else if (addr[12:8] == 5'h1F)
            region = SRC_PAL;
        else
            region = SRC_NAME;
    end

    assign tbl      = addr[OFS_W+1:OFS_W];
    assign bank     = bank_of(mode, tbl);
    assign nt_index = {bank, addr[OFS_W-1:0]};

    always_comb begin
        pal_index = addr[PAL_W-1:0];
        if (addr[4] && (addr[1:0] == 2'b00))
            pal_index[4] = 1'b0;
    end

endmodule

// File: rtl/vmd_ram.sv
module vmd_ram #(
    parameter int DEPTH = 4096,
    parameter int WIDTH = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[addr] <= wdata;
        rdata <= mem[addr];
    end

endmodule

// File: rtl/vram_mirror_decoder.sv
module vram_mirror_decoder
    import vmd_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OFS_W  = 10,
    parameter int PAL_W  = 5,
    localparam int NT_AW    = OFS_W + 2,
    localparam int NT_DEPTH = 1 << NT_AW,
    localparam int PAL_DEPTH = 1 << PAL_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          mirror_mode,
    input  logic [VADDR_W-1:0]  addr,
    input  logic                wr_en,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [DATA_W-1:0]   rd_data
);

    src_e              region;
    src_e              src_q;
    logic [NT_AW-1:0]  nt_index;
    logic [PAL_W-1:0]  pal_index;
    logic              nt_we;
    logic              pal_we;
    logic [DATA_W-1:0] nt_q;
    logic [DATA_W-1:0] pal_q;

    vmd_addr_map #(.OFS_W(OFS_W), .PAL_W(PAL_W)) u_map (
        .mode      (mirror_mode),
        .addr      (addr),
        .region    (region),
        .nt_index  (nt_index),
        .pal_index (pal_index)
    );

    assign nt_we  = wr_en && (region == SRC_NAME);
    assign pal_we = wr_en && (region == SRC_PAL);

    vmd_ram #(.DEPTH(NT_DEPTH), .WIDTH(DATA_W)) u_nt_ram (
        .clk   (clk),
        .we    (nt_we),
        .addr  (nt_index),
        .wdata (wr_data),
        .rdata (nt_q)
    );

    vmd_ram #(.DEPTH(PAL_DEPTH), .WIDTH(DATA_W)) u_pal_ram (
        .clk   (clk),
        .we    (pal_we),
        .addr  (pal_index),
        .wdata (wr_data),
        .rdata (pal_q)
    );

    // State register: which store the registered read comes from
    always_ff @(posedge clk) begin
        if (!rst_n)
            src_q <= SRC_NONE;
        else
            src_q <= region;
    end

    // Output process
    always_comb begin
        unique case (src_q)
            SRC_NAME: rd_data = nt_q;
            SRC_PAL:  rd_data = pal_q;
            default:  rd_data = '0;
        endcase
    end

    // R1: output quiet in the cycle after reset
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> rd_data == '0);

    // R11: nothing outside the window reaches the output or storage
    assert_outside_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        region == SRC_NONE |=> rd_data == '0);
    assert_outside_no_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        region == SRC_NONE |-> !nt_we && !pal_we);

    // R6: single-bank modes pin the bank
    assert_one_lo_bank_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (region == SRC_NAME && mirror_mode == 3'd3) |-> nt_index[NT_AW-1:OFS_W] == 2'd0);
    assert_one_hi_bank_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (region == SRC_NAME && mirror_mode == 3'd4) |-> nt_index[NT_AW-1:OFS_W] == 2'd1);

    // R8: offset passes through for both windows
    assert_offset_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        region == SRC_NAME |-> nt_index[OFS_W-1:0] == addr[OFS_W-1:0]);

    // R10: backdrop slots fold, others untouched
    assert_pal_fold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (region == SRC_PAL && addr[1:0] == 2'b00) |-> pal_index == {1'b0, addr[3:0]});
    assert_pal_plain_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (region == SRC_PAL && addr[1:0] != 2'b00) |-> pal_index == addr[PAL_W-1:0]);

endmodule

// File: tb/tb_vram_mirror_decoder.sv
module tb_vram_mirror_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mirror_mode = 3'd0;
    logic [13:0] addr = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0]  exp;
        logic [13:0] a;
        string       req;
    } item_t;

    item_t sb[$];

    always #10 clk = ~clk;

    vram_mirror_decoder dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .mirror_mode (mirror_mode),
        .addr        (addr),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .rd_data     (rd_data)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp, input logic [13:0] a);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s addr=%h actual=%h expected=%h", req, a, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] m, input logic [13:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        mirror_mode = m; addr = a; wr_en = 1'b0;
        sb.push_back('{exp, a, req});
    endtask

    task automatic wr(input logic [2:0] m, input logic [13:0] a, input logic [7:0] d);
        @(negedge clk);
        mirror_mode = m; addr = a; wr_en = 1'b1; wr_data = d;
    endtask

    task automatic wr_chk(input logic [2:0] m, input logic [13:0] a, input logic [7:0] d,
                          input logic [7:0] old, input string req);
        @(negedge clk);
        mirror_mode = m; addr = a; wr_en = 1'b1; wr_data = d;
        sb.push_back('{old, a, req});
    endtask

    // Monitor: each queued read was presented before this edge
    initial begin
        forever begin
            @(posedge clk);
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                #2;
                check(it.req, rd_data, it.exp, it.a);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", rd_data, 8'h00, addr);
        rst_n = 1'b1;
        @(posedge clk); #2;
        check("R1", rd_data, 8'h00, addr);

        // fill four banks in four-screen mode (R5 write path)
        wr(3'd2, 14'h2055, 8'hA0);
        wr(3'd2, 14'h2455, 8'hA1);
        wr(3'd2, 14'h2855, 8'hA2);
        wr(3'd2, 14'h2C55, 8'hA3);
        rd(3'd2, 14'h2055, 8'hA0, "R5");
        rd(3'd2, 14'h2455, 8'hA1, "R5");
        rd(3'd2, 14'h2855, 8'hA2, "R2");
        rd(3'd2, 14'h2C55, 8'hA3, "R5");
        // horizontal R3
        rd(3'd0, 14'h2455, 8'hA0, "R3");
        rd(3'd0, 14'h2855, 8'hA1, "R3");
        rd(3'd0, 14'h2C55, 8'hA1, "R3");
        // vertical R4
        rd(3'd1, 14'h2455, 8'hA1, "R4");
        rd(3'd1, 14'h2855, 8'hA0, "R4");
        rd(3'd1, 14'h2C55, 8'hA1, "R4");
        // single bank R6
        rd(3'd3, 14'h2C55, 8'hA0, "R6");
        rd(3'd4, 14'h2055, 8'hA1, "R6");
        rd(3'd4, 14'h2855, 8'hA1, "R6");
        // unused modes R7
        rd(3'd5, 14'h2855, 8'hA1, "R7");
        rd(3'd6, 14'h2C55, 8'hA1, "R7");
        rd(3'd7, 14'h2455, 8'hA0, "R7");
        // write through horizontal table 2 lands in bank 1 (R3)
        wr(3'd0, 14'h2855, 8'hB1);
        rd(3'd2, 14'h2455, 8'hB1, "R3");
        // echo window R8
        rd(3'd2, 14'h3C55, 8'hA3, "R8");
        wr(3'd2, 14'h3123, 8'h5A);
        rd(3'd2, 14'h2123, 8'h5A, "R8");
        // palette repeat R9
        wr(3'd0, 14'h3F03, 8'h11);
        rd(3'd0, 14'h3F23, 8'h11, "R9");
        rd(3'd0, 14'h3FE3, 8'h11, "R9");
        // folding R10
        wr(3'd0, 14'h3F10, 8'h22);
        rd(3'd0, 14'h3F00, 8'h22, "R10");
        wr(3'd0, 14'h3F0C, 8'h33);
        rd(3'd0, 14'h3F1C, 8'h33, "R10");
        wr(3'd0, 14'h3F34, 8'h44);
        rd(3'd0, 14'h3F04, 8'h44, "R10");
        wr(3'd0, 14'h3F18, 8'h4C);
        rd(3'd0, 14'h3F08, 8'h4C, "R10");
        wr(3'd0, 14'h3F01, 8'h55);
        wr(3'd0, 14'h3F11, 8'h66);
        rd(3'd0, 14'h3F01, 8'h55, "R10");
        rd(3'd0, 14'h3F11, 8'h66, "R10");
        // outside window R11
        rd(3'd2, 14'h1055, 8'h00, "R11");
        wr(3'd2, 14'h0055, 8'hFF);
        rd(3'd2, 14'h2055, 8'hA0, "R11");
        wr(3'd2, 14'h1F00, 8'hFF);
        rd(3'd2, 14'h3F00, 8'h22, "R11");
        // read during write R12
        wr_chk(3'd2, 14'h2055, 8'h77, 8'hA0, "R12");
        rd(3'd2, 14'h2055, 8'h77, "R2");

        @(negedge clk);
        wr_en = 1'b0;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule